// File: doc/BRIEF.md
# Rejection Sampler for NTT-Domain Polynomial Coefficients

This block converts a stream of pseudorandom bytes into one polynomial of exactly 256 coefficients, each reduced modulo 3329, by rejection sampling. An upstream extendable-output function, outside this block, delivers its bytes three at a time as a 24-bit group on a valid/ready input. Each group is split into two 12-bit candidates. A candidate below 3329 is accepted and sent out. A candidate at or above 3329 is dropped.

A single-cycle start pulse, given while the block is idle, begins a polynomial. Coefficients leave on a 12-bit valid/ready output that honours downstream backpressure. A last flag marks the 256th coefficient. After that coefficient the block asks for no more bytes and emits nothing more until it is back in idle. This holds even when the final group still contains an acceptable candidate: both candidate phases are guarded by the same "more still needed" test.

Top module: `ntt_rejsamp`

## Requirements
- R1: Every coefficient presented with `coef_valid_o` high lies in 0..3328.
- R2: From the group bytes b0 = `grp_data_i[7:0]`, b1 = `grp_data_i[15:8]` and b2 = `grp_data_i[23:16]`, the first candidate is b0 + 256·(b1 mod 16) and the second is floor(b1/16) + 16·b2.
- R3: A candidate is accepted when it is less than 3329. A rejected candidate produces no output transfer and uses no output slot.
- R4: The accepted candidates of a group are emitted in order: the first candidate before the second. Groups are emitted in the order they were taken.
- R5: Each polynomial has exactly 256 output transfers, and `coef_last_o` is high together with `coef_valid_o` on the 256th transfer and on no other.
- R6: Once the transfer carrying `coef_last_o` has happened, `coef_valid_o` stays low until the block is idle again. An acceptable spare candidate in the final group is discarded.
- R7: `grp_ready_o` is high only after both candidates of the previous group (or the start) are resolved and fewer than 256 coefficients have been emitted. It is never high after the 256th transfer.
- R8: `idle_o` is high only while the block is idle, with `coef_valid_o` and `grp_ready_o` low. `start_i` begins a polynomial only when `idle_o` is high. A `start_i` pulse while busy has no effect.
- R9: While `coef_valid_o` is high and `coef_ready_i` is low, `coef_valid_o`, `coef_o` and `coef_last_o` hold their values into the next cycle.
- R10: An active-low `rst_n` puts the block in idle (`idle_o` high, both valids/readies low) with its coefficient count cleared, so the next start yields a full 256 coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin a new polynomial (taken while idle) |
| idle_o | output | 1 | Block is idle and can accept a start |
| grp_data_i | input | 24 | Three-byte group, b0 in the low byte |
| grp_valid_i | input | 1 | Group is present |
| grp_ready_o | output | 1 | Block takes a group this cycle if valid |
| coef_o | output | 12 | Accepted coefficient |
| coef_valid_o | output | 1 | Coefficient is present |
| coef_ready_i | input | 1 | Downstream takes the coefficient |
| coef_last_o | output | 1 | Marks the 256th coefficient |

## Verification
The critical coincidence is the 256th acceptance falling on a group whose other candidate is also acceptable. In that case the end-of-polynomial cutoff and the ordinary second-phase emission meet in the same group, and only the cutoff may win. The bench forces this. When exactly one coefficient is still missing, it supplies a group whose two candidates are both below the modulus, and in another run a group whose first candidate is rejected. It then judges at the ports that the last flag sits on transfer 256 and that no valid pulse or group request follows until idle. Output and input stalls are randomised so that this cutoff also lands on a held, backpressured output.

// File: rtl/rs_pkg.sv
package rs_pkg;

  localparam int CAND_W = 12;
  localparam int GRP_W  = 2 * CAND_W;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FETCH  = 2'd1,
    ST_FIRST  = 2'd2,
    ST_SECOND = 2'd3
  } rs_state_t;

  // First candidate: low byte plus low nibble of the middle byte as bits 11:8.
  function automatic logic [CAND_W-1:0] cand_first(input logic [GRP_W-1:0] g);
    logic [7:0] b0;
    logic [7:0] b1;
    b0 = g[7:0];
    b1 = g[15:8];
    return {b1[3:0], b0};
  endfunction

  // Second candidate: high nibble of the middle byte plus top byte as bits 11:4.
  function automatic logic [CAND_W-1:0] cand_second(input logic [GRP_W-1:0] g);
    logic [7:0] b1;
    logic [7:0] b2;
    b1 = g[15:8];
    b2 = g[23:16];
    return {b2, b1[7:4]};
  endfunction

  function automatic logic cand_accept(input logic [CAND_W-1:0] c, input int unsigned modulus);
    return {20'd0, c} < modulus;
  endfunction

endpackage

// File: rtl/rs_group_hold.sv
module rs_group_hold
  import rs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [GRP_W-1:0]  grp_i,
  input  logic              sel_second_i,
  output logic [CAND_W-1:0] cand_o
);

  logic [GRP_W-1:0] grp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q <= '0;
    end else if (load_i) begin
      grp_q <= grp_i;
    end
  end

  assign cand_o = sel_second_i ? cand_second(grp_q) : cand_first(grp_q);

endmodule

// File: rtl/rs_coef_counter.sv
module rs_coef_counter #(
  parameter int NCOEF = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic incr_i,
  output logic need_more_o,
  output logic at_last_o
);

  localparam int CNT_W = $clog2(NCOEF + 1);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear_i) begin
      count_q <= '0;
    end else if (incr_i) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign need_more_o = count_q < CNT_W'(NCOEF);
  assign at_last_o   = count_q == CNT_W'(NCOEF - 1);

endmodule

// File: rtl/rs_seq_ctrl.sv
module rs_seq_ctrl
  import rs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic grp_valid_i,
  input  logic cand_ok_i,
  input  logic coef_ready_i,
  input  logic need_more_i,
  input  logic at_last_i,
  output logic idle_o,
  output logic grp_ready_o,
  output logic grp_load_o,
  output logic phase_active_o,
  output logic sel_second_o,
  output logic emit_fire_o,
  output logic cnt_clear_o
);

  rs_state_t state_q;
  rs_state_t state_d;
  logic      resolved;
  logic      more_after;

  assign emit_fire_o = cand_ok_i && coef_ready_i;
  // A phase is resolved once its candidate is either dropped or taken.
  assign resolved    = !cand_ok_i || coef_ready_i;
  // Whether another group is wanted once the current phase settles.
  assign more_after  = emit_fire_o ? !at_last_i : need_more_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i)     state_d = ST_FETCH;
      ST_FETCH:  if (grp_valid_i) state_d = ST_FIRST;
      ST_FIRST:  if (resolved)    state_d = ST_SECOND;
      ST_SECOND: if (resolved)    state_d = more_after ? ST_FETCH : ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign idle_o         = state_q == ST_IDLE;
  assign grp_ready_o    = state_q == ST_FETCH;
  assign grp_load_o     = grp_ready_o && grp_valid_i;
  assign phase_active_o = (state_q == ST_FIRST) || (state_q == ST_SECOND);
  assign sel_second_o   = state_q == ST_SECOND;
  assign cnt_clear_o    = idle_o && start_i;

endmodule

// File: rtl/ntt_rejsamp.sv
module ntt_rejsamp
  import rs_pkg::*;
#(
  parameter int NCOEF   = 256,
  parameter int MODULUS = 3329
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              idle_o,
  input  logic [GRP_W-1:0]  grp_data_i,
  input  logic              grp_valid_i,
  output logic              grp_ready_o,
  output logic [CAND_W-1:0] coef_o,
  output logic              coef_valid_o,
  input  logic              coef_ready_i,
  output logic              coef_last_o
);

  // Named internal events
  logic              grp_load;
  logic              phase_active;
  logic              sel_second;
  logic              emit_fire;
  logic              cnt_clear;
  logic              need_more;
  logic              at_last;
  logic [CAND_W-1:0] cand;
  logic              cand_in_range;
  logic              cand_ok;

  rs_group_hold u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (grp_load),
    .grp_i        (grp_data_i),
    .sel_second_i (sel_second),
    .cand_o       (cand)
  );

  rs_coef_counter #(.NCOEF(NCOEF)) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (cnt_clear),
    .incr_i      (emit_fire),
    .need_more_o (need_more),
    .at_last_o   (at_last)
  );

  // Both phases share the same guard: in range and still short of NCOEF.
  assign cand_in_range = cand_accept(cand, MODULUS);
  assign cand_ok       = phase_active && cand_in_range && need_more;

  rs_seq_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .grp_valid_i    (grp_valid_i),
    .cand_ok_i      (cand_ok),
    .coef_ready_i   (coef_ready_i),
    .need_more_i    (need_more),
    .at_last_i      (at_last),
    .idle_o         (idle_o),
    .grp_ready_o    (grp_ready_o),
    .grp_load_o     (grp_load),
    .phase_active_o (phase_active),
    .sel_second_o   (sel_second),
    .emit_fire_o    (emit_fire),
    .cnt_clear_o    (cnt_clear)
  );

  assign coef_o       = cand;
  assign coef_valid_o = cand_ok;
  assign coef_last_o  = cand_ok && at_last;

endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int NCOEF   = 256,
  parameter int MODULUS = 3329
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        idle_o,
  input logic        grp_ready_o,
  input logic [11:0] coef_o,
  input logic        coef_valid_o,
  input logic        coef_ready_i,
  input logic        coef_last_o
);

  localparam int FW = $clog2(NCOEF + 1);

  logic [FW-1:0] fired_q;
  logic          done_q;
  logic          fire;

  assign fire = coef_valid_o && coef_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired_q <= '0;
      done_q  <= 1'b0;
    end else if (idle_o && start_i) begin
      fired_q <= '0;
      done_q  <= 1'b0;
    end else if (fire) begin
      fired_q <= fired_q + 1'b1;
      if (coef_last_o) done_q <= 1'b1;
    end
  end

  a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    coef_valid_o |-> ({20'd0, coef_o} < MODULUS));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_valid_o && !coef_ready_i) |=> (coef_valid_o && $stable(coef_o) && $stable(coef_last_o)));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> (!coef_valid_o && !grp_ready_o));

  a_r6_no_extra: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !coef_valid_o);

  a_r7_no_fetch_after: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !grp_ready_o);

  a_r5_last_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_valid_o && coef_last_o) |-> (fired_q == FW'(NCOEF - 1)));

  a_r5_not_early: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_valid_o && !coef_last_o) |-> (fired_q < FW'(NCOEF - 1)));

endmodule

bind ntt_rejsamp rs_checker #(.NCOEF(NCOEF), .MODULUS(MODULUS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .idle_o       (idle_o),
  .grp_ready_o  (grp_ready_o),
  .coef_o       (coef_o),
  .coef_valid_o (coef_valid_o),
  .coef_ready_i (coef_ready_i),
  .coef_last_o  (coef_last_o)
);

// File: tb/ntt_rejsamp_tb_top.sv
module ntt_rejsamp_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NC  = 256;
  localparam int MOD = 3329;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        idle_o;
  logic [23:0] grp_data_i = '0;
  logic        grp_valid_i = 1'b0;
  logic        grp_ready_o;
  logic [11:0] coef_o;
  logic        coef_valid_o;
  logic        coef_ready_i = 1'b0;
  logic        coef_last_o;

  int checks = 0;
  int fails  = 0;
  int unsigned rs = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  ntt_rejsamp dut_i (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .idle_o (idle_o),
    .grp_data_i (grp_data_i), .grp_valid_i (grp_valid_i), .grp_ready_o (grp_ready_o),
    .coef_o (coef_o), .coef_valid_o (coef_valid_o), .coef_ready_i (coef_ready_i),
    .coef_last_o (coef_last_o)
  );

  function automatic int unsigned rnd();
    rs ^= rs << 13;
    rs ^= rs >> 17;
    rs ^= rs << 5;
    return rs;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Build bytes from two wanted candidates (inverse of R2).
  function automatic logic [23:0] make_grp(input int c0, input int c1);
    int b0, b1, b2;
    b0 = c0 % 256;
    b1 = (c0 / 256) + 16 * (c1 % 16);
    b2 = c1 / 16;
    return {b2[7:0], b1[7:0], b0[7:0]};
  endfunction

  // mode 0 random, 1 mostly rejected, 2 boundary values, 3 sweep
  function automatic logic [23:0] next_grp(input int mode, input int sweep, input int k,
                                           input int pushed, input int force_kind);
    int bv [6] = '{3327, 3328, 3329, 4095, 0, 1};
    int i, j;
    if (pushed == NC - 1 && force_kind == 1) return make_grp(3328, 7);
    if (pushed == NC - 1 && force_kind == 2) return make_grp(4000, 3328);
    case (mode)
      1: return ((rnd() % 4) != 0) ? 24'hFFFFFF : 24'(rnd());
      2: begin
        i = (2 * k + k / 3) % 6;
        j = (i + 1 + k % 2) % 6;
        return make_grp(bv[i], bv[j]);
      end
      3: return make_grp((sweep * 512 + 2 * k) % 4096, (sweep * 512 + 2 * k + 1) % 4096);
      default: return 24'(rnd());
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    start_i = 1'b0;
    grp_valid_i = 1'b0;
    coef_ready_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R10: reset state seen at the ports
    check(idle_o === 1'b1, "R10 idle after reset", idle_o, 1);
    check(grp_ready_o === 1'b0 && coef_valid_o === 1'b0, "R10 quiet after reset",
          {grp_ready_o, coef_valid_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_poly(input int mode, input int sweep, input bit stall,
                          input bit busy_start, input int force_kind, input int abort_at);
    int expq[$];
    int pushed = 0, idx = 0, k = 0, cyc = 0, extra = 0;
    bit prev_stall = 0;
    int prev_coef = 0;
    bit rdy, gv;
    logic [23:0] g;
    int b0, b1, b2, c0, c1, e;

    check(idle_o === 1'b1, "R8 idle before start", idle_o, 1);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!idle_o) begin
      if (cyc > 30000) begin
        check(0, "R5 poly timeout", idx, NC);
        break;
      end
      if (prev_stall)
        check(coef_valid_o === 1'b1 && int'(coef_o) == prev_coef, "R9 hold under stall",
              int'(coef_o), prev_coef);
      if (idx >= NC && coef_valid_o) extra++;
      if (idx == abort_at) begin
        do_reset();
        return;
      end
      rdy = stall ? ((rnd() % 4) != 0) : 1'b1;
      coef_ready_i = rdy;
      if (coef_valid_o && rdy) begin
        e = (expq.size() > 0) ? expq.pop_front() : -1;
        check(int'(coef_o) == e, "R2/R3/R4 coefficient value", int'(coef_o), e);
        check(int'(coef_o) < MOD, "R1 range", int'(coef_o), MOD - 1);
        check(coef_last_o === (idx == NC - 1), "R5 last flag position", coef_last_o, idx == NC - 1);
        idx++;
      end
      prev_stall = coef_valid_o && !rdy;
      prev_coef  = int'(coef_o);
      start_i = busy_start && (cyc % 97 == 50);   // R8: ignored while busy
      gv = stall ? ((rnd() % 3) != 0) : 1'b1;
      g  = next_grp(mode, sweep, k, pushed, force_kind);
      grp_valid_i = gv;
      grp_data_i  = g;
      if (grp_ready_o) begin
        if (pushed >= NC) check(0, "R7 group requested after 256th", pushed, NC - 1);
        if (gv) begin
          k++;
          b0 = int'(g[7:0]);
          b1 = int'(g[15:8]);
          b2 = int'(g[23:16]);
          c0 = b0 + 256 * (b1 % 16);
          c1 = b1 / 16 + 16 * b2;
          if (c0 < MOD && pushed < NC) begin expq.push_back(c0); pushed++; end
          if (c1 < MOD && pushed < NC) begin expq.push_back(c1); pushed++; end
        end
      end
      @(negedge clk);
      start_i = 1'b0;
      cyc++;
    end
    grp_valid_i = 1'b0;
    check(idx == NC, "R5 total transfers", idx, NC);
    check(extra == 0, "R6 no valid after last", extra, 0);
    check(expq.size() == 0, "R4 all accepted emitted", expq.size(), 0);
    check(grp_ready_o === 1'b0 && coef_valid_o === 1'b0, "R8 idle quiet",
          {grp_ready_o, coef_valid_o}, 0);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    run_poly(0, 0, 0, 0, 0, -1);
    run_poly(0, 0, 1, 1, 1, -1);  // R6 spare acceptable candidate dropped
    run_poly(1, 0, 1, 0, 2, -1);  // 256th from second phase
    run_poly(2, 0, 1, 1, 1, -1);
    run_poly(2, 0, 0, 0, 2, -1);
    for (int s = 0; s < 8; s++) run_poly(3, s, s % 2 == 1, 0, (s % 3 == 0) ? 1 : 0, -1);
    run_poly(0, 0, 1, 0, 0, 100); // R10 reset mid-polynomial
    run_poly(0, 0, 1, 0, 1, -1);  // R10 full count after reset
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule